// File: doc/BRIEF.md
# Run-Time Allocated Address Window Router

This block sits inside a bus bridge between a processor-side bus and a fixed set of physical module ports. Unlike a decoder with a synthesis-time address map, its windows are created and removed while the system runs. Each loaded module gets its own window, and two copies of the same module on different ports get two independent windows. Software allocates a window straight after a module has been loaded and before it touches that module. It does so with three configuration writes: the window start, then the window length, then the physical port number. The port write commits the entry.

A bus access whose address lands in a live window is forwarded to that window's port, with the address rebased to an offset from the window start. The access is held there until the port acknowledges it. If the port has been emptied and never answers, a cycle limit ends the access with an error. An access that hits no window is answered at once with an error and reaches no port. Releasing a port invalidates every window that points at it, and the bus can stay in use while entries come and go.

Top module: `win_router`

## Requirements
- R1: After reset the table holds no live window, no port request is raised, `cfg_err` and `m_done` are low, and any bus access is answered with `m_err`=1.
- R2: Configuration writes use `cfg_sel`: 0 loads the window start, 1 loads the window length, and 2 commits an entry with `cfg_wdata` as the port number. A commit that is accepted makes the window live for the next access.
- R3: An access with start <= `m_addr` < start+length raises exactly one bit of `p_req`, the bit of the window's port. It presents `m_addr`-start on `p_addr`, along with `m_we` and `m_wdata`. It completes with `m_err`=0, and for reads `m_rdata` carries that port's `p_rdata` slice.
- R4: An access that matches no live window (the byte at start+length included) completes with `m_err`=1 and raises no port request.
- R5: A commit with a length of zero is rejected: `cfg_err` pulses for one cycle after the write, and no window is added.
- R6: A commit whose window overlaps any live window is rejected with a `cfg_err` pulse and no change to the table.
- R7: When all NENT entries are live, a further commit is rejected with a `cfg_err` pulse. A slot freed later can be reused.
- R8: A commit naming a port number >= NPORT is rejected with a `cfg_err` pulse.
- R9: A write with `cfg_sel`=3 and a port number in `cfg_wdata` invalidates every window bound to that port and leaves the other windows live.
- R10: Windows bound to different ports decode independently, each rebasing to its own start.
- R11: A forwarded access keeps its port request until that port's `p_ack`. If no acknowledge comes within TMO cycles, the access completes with `m_err`=1 and the request is dropped.
- R12: Only one access is in flight at a time. `m_done` is a single-cycle pulse, and `m_err`/`m_rdata` are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 start, 1 length, 2 commit with port, 3 free port |
| cfg_wdata | input | AW | Configuration write data |
| cfg_err | output | 1 | One-cycle pulse after a rejected commit |
| m_req | input | 1 | Bus access request, held until `m_done` |
| m_we | input | 1 | Bus write when 1, read when 0 |
| m_addr | input | AW | Bus address |
| m_wdata | input | DW | Bus write data |
| m_done | output | 1 | Access completion pulse |
| m_err | output | 1 | Error status of the completed access |
| m_rdata | output | DW | Read data of the completed access |
| p_req | output | NPORT | One request line per physical port |
| p_we | output | 1 | Write flag toward the port |
| p_addr | output | AW | Offset inside the window |
| p_wdata | output | DW | Write data toward the port |
| p_ack | input | NPORT | Per-port acknowledge |
| p_rdata | input | NPORT*DW | Per-port read data, port k in slice k |

## Verification
The bench builds the router with AW=16, DW=16, NPORT=4, NENT=3 and TMO=8. Three table entries are few enough that a full table and slot reuse after a release are reached in a short sequence. Four ports leave room for an out-of-range port number and for one port modelled as a removed module that never answers. The short timeout puts the abandoned-access path within a handful of cycles. The port models reply with data that encodes their own index and the received offset, so a wrong route or a wrong rebase shows in the read value.

// File: rtl/win_router.sv
module win_router #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int NPORT = 4,
  parameter int NENT  = 3,
  parameter int TMO   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [AW-1:0]       cfg_wdata,
  output logic                cfg_err,
  input  logic                m_req,
  input  logic                m_we,
  input  logic [AW-1:0]       m_addr,
  input  logic [DW-1:0]       m_wdata,
  output logic                m_done,
  output logic                m_err,
  output logic [DW-1:0]       m_rdata,
  output logic [NPORT-1:0]    p_req,
  output logic                p_we,
  output logic [AW-1:0]       p_addr,
  output logic [DW-1:0]       p_wdata,
  input  logic [NPORT-1:0]    p_ack,
  input  logic [NPORT*DW-1:0] p_rdata
);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int TW = $clog2(TMO + 1);
  localparam logic [AW-1:0] NPW = AW'(NPORT);
  localparam logic [TW-1:0] TLAST = TW'(TMO - 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_RESP} st_t;

  logic [NENT-1:0] vld;
  logic [AW-1:0]   ebase [NENT];
  logic [AW-1:0]   elen  [NENT];
  logic [PW-1:0]   eport [NENT];
  logic [AW-1:0]   nbase, nlen;

  st_t           st;
  logic [PW-1:0] cur;
  logic [TW-1:0] tcnt;

  logic          hit;
  logic [PW-1:0] hport;
  logic [AW-1:0] hoff;
  always_comb begin
    hit = 1'b0;
    hport = '0;
    hoff = '0;
    for (int i = 0; i < NENT; i++)
      if (!hit && vld[i] && m_addr >= ebase[i] &&
          {1'b0, m_addr} < ({1'b0, ebase[i]} + {1'b0, elen[i]})) begin
        hit = 1'b1;
        hport = eport[i];
        hoff = m_addr - ebase[i];
      end
  end

  logic ovl, has_free, accept;
  logic [NENT-1:0] slot;
  always_comb begin
    ovl = 1'b0;
    has_free = 1'b0;
    slot = '0;
    for (int i = 0; i < NENT; i++) begin
      if (vld[i] &&
          ({1'b0, nbase} < ({1'b0, ebase[i]} + {1'b0, elen[i]})) &&
          ({1'b0, ebase[i]} < ({1'b0, nbase} + {1'b0, nlen})))
        ovl = 1'b1;
      if (!vld[i] && !has_free) begin
        has_free = 1'b1;
        slot[i] = 1'b1;
      end
    end
  end
  assign accept = (nlen != '0) && !ovl && has_free && (cfg_wdata < NPW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      nbase <= '0;
      nlen <= '0;
      cfg_err <= 1'b0;
      for (int i = 0; i < NENT; i++) begin
        ebase[i] <= '0;
        elen[i] <= '0;
        eport[i] <= '0;
      end
    end else begin
      cfg_err <= 1'b0;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: nbase <= cfg_wdata;
          2'd1: nlen <= cfg_wdata;
          2'd2: begin
            if (accept) begin
              for (int i = 0; i < NENT; i++)
                if (slot[i]) begin
                  vld[i] <= 1'b1;
                  ebase[i] <= nbase;
                  elen[i] <= nlen;
                  eport[i] <= cfg_wdata[PW-1:0];
                end
            end else begin
              cfg_err <= 1'b1;
            end
          end
          default: begin
            for (int i = 0; i < NENT; i++)
              if (vld[i] && {{(AW-PW){1'b0}}, eport[i]} == cfg_wdata)
                vld[i] <= 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0;
      tcnt <= '0;
      m_err <= 1'b0;
      m_rdata <= '0;
      p_we <= 1'b0;
      p_addr <= '0;
      p_wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (m_req) begin
          tcnt <= '0;
          if (hit) begin
            st <= S_BUSY;
            cur <= hport;
            p_addr <= hoff;
            p_we <= m_we;
            p_wdata <= m_wdata;
          end else begin
            st <= S_RESP;
            m_err <= 1'b1;
            m_rdata <= '0;
          end
        end
        S_BUSY: begin
          if (p_ack[cur]) begin
            st <= S_RESP;
            m_err <= 1'b0;
            m_rdata <= p_we ? '0 : p_rdata[cur*DW +: DW];
          end else if (tcnt == TLAST) begin
            st <= S_RESP;
            m_err <= 1'b1;
            m_rdata <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign m_done = (st == S_RESP);
  assign p_req  = (st == S_BUSY) ? (NPORT'(1) << cur) : '0;

  // R3
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_req));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |=> !m_done);

  // R5
  cfg_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we && cfg_sel == 2'd2));

  // R11
  ok_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_done && !m_err) |-> $past(|(p_req & p_ack)));

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|p_req && !(|(p_req & p_ack)) && tcnt != TLAST) |=> $stable(p_req));

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_done && m_err) |-> (p_req == '0));
endmodule

// File: tb/win_router_bench.sv
module win_router_bench;
  localparam int AW = 16, DW = 16, NP = 4, NE = 3, TMO = 8;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [AW-1:0] cfg_wdata = 0;
  logic cfg_err;
  logic m_req = 0, m_we = 0; logic [AW-1:0] m_addr = 0; logic [DW-1:0] m_wdata = 0;
  logic m_done, m_err; logic [DW-1:0] m_rdata;
  logic [NP-1:0] p_req; logic p_we; logic [AW-1:0] p_addr; logic [DW-1:0] p_wdata;
  logic [NP-1:0] p_ack = 0; logic [NP*DW-1:0] p_rdata;

  win_router #(.AW(AW), .DW(DW), .NPORT(NP), .NENT(NE), .TMO(TMO)) u_win_router (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cfg_err,
    .m_req, .m_we, .m_addr, .m_wdata, .m_done, .m_err, .m_rdata,
    .p_req, .p_we, .p_addr, .p_wdata, .p_ack, .p_rdata);

  int total = 0, bad = 0;
  logic [NP-1:0] dead = 0;
  int cnt [NP];
  logic [AW-1:0] last_addr [NP];
  logic last_we [NP];
  logic [DW-1:0] last_wdata [NP];

  always_comb
    for (int i = 0; i < NP; i++) p_rdata[i*DW +: DW] = {4'hA, 4'(i), p_addr[7:0]};

  always @(posedge clk)
    for (int i = 0; i < NP; i++) begin
      if (p_req[i] && !p_ack[i] && !dead[i]) begin
        if (cnt[i] >= i) begin
          p_ack[i] <= 1'b1; cnt[i] <= 0;
          last_addr[i] <= p_addr; last_we[i] <= p_we; last_wdata[i] <= p_wdata;
        end else cnt[i] <= cnt[i] + 1;
      end else begin
        p_ack[i] <= 1'b0;
        if (!p_req[i]) cnt[i] <= 0;
      end
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [AW-1:0] d, output logic err);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; err = cfg_err;
  endtask

  task automatic alloc(input logic [AW-1:0] b, input logic [AW-1:0] l,
                       input logic [AW-1:0] p, output logic err);
    logic e;
    cfg_wr(2'd0, b, e); cfg_wr(2'd1, l, e); cfg_wr(2'd2, p, err);
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic err, output logic [DW-1:0] rd, output int lat);
    @(negedge clk); m_req = 1; m_we = we; m_addr = a; m_wdata = wd; lat = 0;
    do begin @(negedge clk); lat++; end while (!m_done && lat < 100);
    err = m_err; rd = m_rdata; m_req = 0;
    @(negedge clk);
    chk("R12 done pulse", {31'd0, m_done}, 32'd0);
  endtask

  task automatic t_reset;
    logic e; logic [DW-1:0] r; int l;
    chk("R1 p_req", {28'd0, p_req}, 0);
    chk("R1 cfg_err", {31'd0, cfg_err}, 0);
    chk("R1 m_done", {31'd0, m_done}, 0);
    access(0, 16'h0000, 0, e, r, l);
    chk("R1 empty table err", {31'd0, e}, 1);
  endtask

  task automatic t_basic;
    logic e; logic [DW-1:0] r; int l;
    alloc(16'h1000, 16'h0100, 2, e);
    chk("R2 commit ok", {31'd0, e}, 0);
    access(0, 16'h1010, 0, e, r, l);
    chk("R3 read err", {31'd0, e}, 0);
    chk("R3 read data", {16'd0, r}, 32'hA210);
    chk("R3 offset", {16'd0, last_addr[2]}, 32'h10);
    access(1, 16'h10FF, 16'h5A5A, e, r, l);
    chk("R3 write err", {31'd0, e}, 0);
    chk("R3 write offset", {16'd0, last_addr[2]}, 32'hFF);
    chk("R3 write flag", {31'd0, last_we[2]}, 1);
    chk("R3 write data", {16'd0, last_wdata[2]}, 32'h5A5A);
    access(0, 16'h1100, 0, e, r, l);
    chk("R4 end exclusive", {31'd0, e}, 1);
    access(0, 16'h0FFF, 0, e, r, l);
    chk("R4 below start", {31'd0, e}, 1);
  endtask

  task automatic t_twin;
    logic e; logic [DW-1:0] r; int l;
    alloc(16'h2000, 16'h0040, 3, e);
    chk("R10 second commit", {31'd0, e}, 0);
    access(0, 16'h2004, 0, e, r, l);
    chk("R10 port3 data", {16'd0, r}, 32'hA304);
    chk("R11 held for delayed ack", {31'd0, l >= 4}, 1);
    access(0, 16'h1004, 0, e, r, l);
    chk("R10 port2 data", {16'd0, r}, 32'hA204);
  endtask

  task automatic t_reject;
    logic e; logic [DW-1:0] r; int l;
    alloc(16'h3000, 16'h0000, 1, e);
    chk("R5 zero length", {31'd0, e}, 1);
    alloc(16'h10F0, 16'h0020, 1, e);
    chk("R6 overlap", {31'd0, e}, 1);
    access(0, 16'h1105, 0, e, r, l);
    chk("R6 table unchanged", {31'd0, e}, 1);
    alloc(16'h3000, 16'h0010, 7, e);
    chk("R8 bad port", {31'd0, e}, 1);
    access(0, 16'h3000, 0, e, r, l);
    chk("R5 R8 not added", {31'd0, e}, 1);
    alloc(16'h4000, 16'h0010, 0, e);
    chk("R7 third entry", {31'd0, e}, 0);
    alloc(16'h5000, 16'h0010, 1, e);
    chk("R7 table full", {31'd0, e}, 1);
    access(0, 16'h5000, 0, e, r, l);
    chk("R7 full not added", {31'd0, e}, 1);
  endtask

  task automatic t_free;
    logic e; logic [DW-1:0] r; int l;
    cfg_wr(2'd3, 16'd2, e);
    access(0, 16'h1010, 0, e, r, l);
    chk("R9 freed window", {31'd0, e}, 1);
    access(0, 16'h2004, 0, e, r, l);
    chk("R9 other kept", {16'd0, r}, 32'hA304);
    alloc(16'h5000, 16'h0010, 1, e);
    chk("R7 slot reuse", {31'd0, e}, 0);
    access(0, 16'h5003, 0, e, r, l);
    chk("R7 reused window", {16'd0, r}, 32'hA103);
  endtask

  task automatic t_timeout;
    logic e; logic [DW-1:0] r; int l;
    dead[0] = 1;
    access(0, 16'h4001, 0, e, r, l);
    chk("R11 timeout err", {31'd0, e}, 1);
    chk("R11 waited TMO", {31'd0, l >= TMO}, 1);
    chk("R11 req dropped", {28'd0, p_req}, 0);
    dead[0] = 0;
    access(0, 16'h4002, 0, e, r, l);
    chk("R11 port recovers", {16'd0, r}, 32'hA002);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      cnt[i] = 0; last_addr[i] = 0; last_we[i] = 0; last_wdata[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_twin();
    t_reject();
    t_free();
    t_timeout();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule